// File: doc/BRIEF.md
# Configurable Serial Line Transmitter

This block turns bytes into asynchronous serial characters on a single output line. A byte is handed over with a valid/ready handshake. The character is sent as a low start bit, then the data bits least significant first, then an optional parity bit, then one or two high stop bits. The line rests high between characters. The character format is sampled from the control inputs at the moment the byte is accepted, so a format change never tears a character in two.

Bit timing comes from a fixed base tick. A fractional accumulator running on the module clock produces this tick, 921600 Hz by default. Each bit lasts (divisor + 1) ticks. A new divisor is written with a strobe and is only taken up between characters. A busy flag stays high until the new value is in force, and no byte is accepted while it is high. A break control holds the line low. It abandons any character in flight and blocks new bytes until the break control is released.

Top module: `serial_line_tx`

## Requirements
- R1: After reset the line is high, the divisor-busy and line-active flags are low, and the divisor in force is 7, so a bit lasts 8 ticks.
- R2: A character is a start bit at 0, then the data bits LSB first, then the stop bits at 1. While no character is sent and no break is requested, the line is 1.
- R3: With `wide8_i` = 1 eight data bits are sent. With `wide8_i` = 0 seven are sent: bits 6..0, with bit 7 of the byte dropped and the first stop bit following bit 6.
- R4: With `par_en_i` = 1 a parity bit follows the data bits. With `par_odd_i` = 0 it makes the count of ones over data and parity even. With `par_odd_i` = 1 it makes that count odd.
- R5: With `two_stop_i` = 1 two stop bits are sent, otherwise one. `line_active_o` stays high through the last stop bit and is low one bit time later when no byte follows.
- R6: Every bit lasts exactly (divisor + 1) ticks of the base tick. The tick is derived from the module clock as TICK_HZ/CLK_HZ, and the divisor in force does not change inside a character.
- R7: A pulse on `div_wr_i` raises `div_busy_o` on the next clock. The value takes effect at the next character boundary: one clock later when the line is idle, or at the end of the character being sent. `in_ready_o` is low while `div_busy_o` is high.
- R8: While `brk_i` is 1 the line is driven 0 from the next clock, any character in flight is dropped, and `in_ready_o` is 0. After release the line returns to 1.
- R9: While `tx_en_i` is 0 `in_ready_o` is 0, no byte is taken, and the line stays idle high.
- R10: A byte is taken only on a clock where `in_valid_i` and `in_ready_o` are both 1. `line_active_o` is high from the clock after acceptance until the character ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Module clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| in_valid_i | input | 1 | Byte offered |
| in_data_i | input | 8 | Byte to send |
| in_ready_o | output | 1 | Byte will be taken this clock |
| div_val_i | input | DIV_W | New divisor value |
| div_wr_i | input | 1 | Divisor write strobe |
| tx_en_i | input | 1 | Transmitter enable |
| wide8_i | input | 1 | 1: eight data bits, 0: seven |
| par_en_i | input | 1 | Parity bit enable |
| par_odd_i | input | 1 | 1: odd parity, 0: even |
| two_stop_i | input | 1 | 1: two stop bits |
| brk_i | input | 1 | Hold line low (break) |
| tx_o | output | 1 | Serial output line |
| line_active_o | output | 1 | Character in progress |
| div_busy_o | output | 1 | Divisor update not yet in force |

## Verification
Characters are sent with the default divisor and with divisors 0 and 3, using the alternating pattern 0xA5, which shows any drift in bit time or wrong bit order. A byte with bit 7 set is sent in 7-bit mode to show that bit 7 is dropped. Bytes with even and odd counts of ones are sent under both parity senses, so a swapped or missing parity bit is caught. Two-stop and one-stop frames are told apart by the active flag one bit after the last stop bit. A divisor written in the middle of a character must leave that character at the old rate and the next one at the new rate. A break or a disabled transmitter must show a low or idle line at the port.

// File: rtl/serial_tx_pkg.sv
package serial_tx_pkg;

  localparam int BYTE_W = 8;
  localparam int IDX_W  = 3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } tx_state_e;

  typedef struct packed {
    logic wide8;
    logic par_en;
    logic par_odd;
    logic two_stop;
  } frame_cfg_t;

  function automatic logic frame_parity(logic [BYTE_W-1:0] d, frame_cfg_t c);
    logic [BYTE_W-1:0] m;
    m = c.wide8 ? d : {1'b0, d[BYTE_W-2:0]};
    return (^m) ^ c.par_odd;
  endfunction

endpackage

// File: rtl/baud_tick_gen.sv
module baud_tick_gen #(
  parameter int CLK_HZ  = 24000000,
  parameter int TICK_HZ = 921600
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  output logic tick_o
);
  localparam int ACC_W = $clog2(CLK_HZ + TICK_HZ + 1);
  localparam logic [ACC_W-1:0] STEP  = ACC_W'(TICK_HZ);
  localparam logic [ACC_W-1:0] LIMIT = ACC_W'(CLK_HZ);

  logic [ACC_W-1:0] acc_q, acc_d, sum;
  logic             wrap;

  always_comb begin
    sum  = acc_q + STEP;
    wrap = (sum >= LIMIT);
    if (clr_i)     acc_d = '0;
    else if (wrap) acc_d = sum - LIMIT;
    else           acc_d = sum;
    tick_o = !clr_i && wrap;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) acc_q <= '0;
    else         acc_q <= acc_d;
  end
endmodule

// File: rtl/bit_timer.sv
module bit_timer #(
  parameter int DIV_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             bit_end_o
);
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    bit_end_o = run_i && tick_i && (cnt_q == div_i);
    cnt_en    = !run_i || tick_i;
    if (!run_i || bit_end_o) cnt_d = '0;
    else                     cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/div_ctl.sv
module div_ctl #(
  parameter int DIV_W     = 10,
  parameter int DIV_RESET = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [DIV_W-1:0] val_i,
  input  logic             boundary_i,
  output logic [DIV_W-1:0] div_o,
  output logic             busy_o
);
  logic             pend_q, pend_d;
  logic [DIV_W-1:0] val_q, val_d, act_q, act_d;
  logic             apply;

  always_comb begin
    apply  = pend_q && boundary_i && !wr_i;
    pend_d = pend_q;
    val_d  = val_q;
    act_d  = act_q;
    if (wr_i) begin
      pend_d = 1'b1;
      val_d  = val_i;
    end else if (apply) begin
      pend_d = 1'b0;
      act_d  = val_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      val_q  <= DIV_W'(DIV_RESET);
      act_q  <= DIV_W'(DIV_RESET);
    end else begin
      pend_q <= pend_d;
      if (wr_i)  val_q <= val_d;
      if (apply) act_q <= act_d;
    end
  end

  assign div_o  = act_q;
  assign busy_o = pend_q;
endmodule

// File: rtl/tx_frame_fsm.sv
module tx_frame_fsm
  import serial_tx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tx_en_i,
  input  logic              brk_i,
  input  logic              hold_i,
  input  frame_cfg_t        cfg_i,
  input  logic              in_valid_i,
  input  logic [BYTE_W-1:0] in_data_i,
  input  logic              bit_end_i,
  output logic              in_ready_o,
  output logic              active_o,
  output logic              tx_o
);
  tx_state_e         st_q, st_d;
  logic [IDX_W-1:0]  idx_q, idx_d, last_idx;
  logic [BYTE_W-1:0] sh_q, sh_d;
  frame_cfg_t        cfg_q, cfg_d;
  logic              par_q, par_d;
  logic              line_q, line_d;
  logic              accept;

  always_comb begin
    in_ready_o = (st_q == ST_IDLE) && tx_en_i && !brk_i && !hold_i;
    accept     = in_ready_o && in_valid_i;
    last_idx   = cfg_q.wide8 ? IDX_W'(BYTE_W - 1) : IDX_W'(BYTE_W - 2);
    st_d  = st_q;
    idx_d = idx_q;
    sh_d  = sh_q;
    cfg_d = cfg_q;
    par_d = par_q;
    if (brk_i) begin
      st_d = ST_IDLE;
    end else begin
      case (st_q)
        ST_IDLE: if (accept) begin
          st_d  = ST_START;
          idx_d = '0;
          sh_d  = in_data_i;
          cfg_d = cfg_i;
          par_d = frame_parity(in_data_i, cfg_i);
        end
        ST_START: if (bit_end_i) st_d = ST_DATA;
        ST_DATA: if (bit_end_i) begin
          sh_d = {1'b0, sh_q[BYTE_W-1:1]};
          if (idx_q == last_idx) begin
            idx_d = '0;
            st_d  = cfg_q.par_en ? ST_PAR : ST_STOP;
          end else begin
            idx_d = idx_q + 1'b1;
          end
        end
        ST_PAR: if (bit_end_i) st_d = ST_STOP;
        ST_STOP: if (bit_end_i) begin
          if (cfg_q.two_stop && (idx_q == '0)) idx_d = idx_q + 1'b1;
          else                                 st_d  = ST_IDLE;
        end
        default: st_d = ST_IDLE;
      endcase
    end
    if (brk_i) line_d = 1'b0;
    else begin
      case (st_q)
        ST_START: line_d = 1'b0;
        ST_DATA:  line_d = sh_q[0];
        ST_PAR:   line_d = par_q;
        default:  line_d = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      idx_q  <= '0;
      sh_q   <= '0;
      cfg_q  <= '0;
      par_q  <= 1'b0;
      line_q <= 1'b1;
    end else begin
      st_q   <= st_d;
      idx_q  <= idx_d;
      sh_q   <= sh_d;
      par_q  <= par_d;
      line_q <= line_d;
      if (accept) cfg_q <= cfg_d;
    end
  end

  assign active_o = (st_q != ST_IDLE);
  assign tx_o     = line_q;
endmodule

// File: rtl/serial_line_tx.sv
module serial_line_tx
  import serial_tx_pkg::*;
#(
  parameter int CLK_HZ    = 24000000,
  parameter int TICK_HZ   = 921600,
  parameter int DIV_W     = 10,
  parameter int DIV_RESET = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  input  logic [BYTE_W-1:0] in_data_i,
  output logic              in_ready_o,
  input  logic [DIV_W-1:0]  div_val_i,
  input  logic              div_wr_i,
  input  logic              tx_en_i,
  input  logic              wide8_i,
  input  logic              par_en_i,
  input  logic              par_odd_i,
  input  logic              two_stop_i,
  input  logic              brk_i,
  output logic              tx_o,
  output logic              line_active_o,
  output logic              div_busy_o
);
  logic             rst_meta_n, rst_sync_n;
  logic             tick, bit_end, active;
  logic [DIV_W-1:0] div_act;
  frame_cfg_t       cfg;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  always_comb begin
    cfg.wide8    = wide8_i;
    cfg.par_en   = par_en_i;
    cfg.par_odd  = par_odd_i;
    cfg.two_stop = two_stop_i;
  end

  baud_tick_gen #(.CLK_HZ(CLK_HZ), .TICK_HZ(TICK_HZ)) u_tick (
    .clk_i(clk_i), .rst_ni(rst_sync_n), .clr_i(!active), .tick_o(tick)
  );

  bit_timer #(.DIV_W(DIV_W)) u_timer (
    .clk_i(clk_i), .rst_ni(rst_sync_n), .run_i(active), .tick_i(tick),
    .div_i(div_act), .bit_end_o(bit_end)
  );

  div_ctl #(.DIV_W(DIV_W), .DIV_RESET(DIV_RESET)) u_div (
    .clk_i(clk_i), .rst_ni(rst_sync_n), .wr_i(div_wr_i), .val_i(div_val_i),
    .boundary_i(!active), .div_o(div_act), .busy_o(div_busy_o)
  );

  tx_frame_fsm u_fsm (
    .clk_i(clk_i), .rst_ni(rst_sync_n), .tx_en_i(tx_en_i), .brk_i(brk_i),
    .hold_i(div_busy_o), .cfg_i(cfg), .in_valid_i(in_valid_i),
    .in_data_i(in_data_i), .bit_end_i(bit_end), .in_ready_o(in_ready_o),
    .active_o(active), .tx_o(tx_o)
  );

  assign line_active_o = active;
endmodule

// File: rtl/serial_line_tx_chk.sv
module serial_line_tx_chk #(
  parameter int DIV_W = 10
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             brk_i,
  input logic             tx_en_i,
  input logic             tx_o,
  input logic             in_ready_o,
  input logic             line_active_o,
  input logic             div_busy_o,
  input logic [DIV_W-1:0] div_act
);
  // R8
  brk_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    brk_i |=> !tx_o);

  // R2
  idle_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!line_active_o && !brk_i) |=> tx_o);

  // R7
  busy_blocks_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_ready_o |-> !div_busy_o);

  // R7
  busy_clear_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(div_busy_o) |-> !line_active_o);

  // R6
  div_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(line_active_o) && line_active_o) |-> $stable(div_act));

  // R9
  en_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_en_i |-> !in_ready_o);
endmodule

bind serial_line_tx serial_line_tx_chk #(.DIV_W(DIV_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_sync_n), .brk_i(brk_i), .tx_en_i(tx_en_i),
  .tx_o(tx_o), .in_ready_o(in_ready_o), .line_active_o(line_active_o),
  .div_busy_o(div_busy_o), .div_act(div_act)
);

// File: tb/sim_serial_line_tx.sv
module sim_serial_line_tx;
  localparam int DIV_W = 10;
  localparam int CPT   = 4; // clocks per tick in this bench

  logic             clk, rst_n;
  logic             in_valid, in_ready, div_wr, tx_en, wide8, par_en, par_odd, two_stop, brk;
  logic [7:0]       in_data;
  logic [DIV_W-1:0] div_val;
  logic             tx, active, busy;
  int               n_checks = 0;
  int               n_errors = 0;

  serial_line_tx #(.CLK_HZ(CPT), .TICK_HZ(1), .DIV_W(DIV_W), .DIV_RESET(7)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_data_i(in_data),
    .in_ready_o(in_ready), .div_val_i(div_val), .div_wr_i(div_wr),
    .tx_en_i(tx_en), .wide8_i(wide8), .par_en_i(par_en), .par_odd_i(par_odd),
    .two_stop_i(two_stop), .brk_i(brk), .tx_o(tx), .line_active_o(active),
    .div_busy_o(busy)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic adv(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_byte(input logic [7:0] d);
    int guard = 0;
    while (!in_ready && guard < 2000) begin adv(1); guard++; end
    in_data  = d;
    in_valid = 1'b1;
    adv(1);
    in_valid = 1'b0;
  endtask

  task automatic set_div(input int v);
    div_val = DIV_W'(v);
    div_wr  = 1'b1;
    adv(1);
    div_wr  = 1'b0;
  endtask

  // Sample one character at bit centres and compare against the format.
  task automatic check_frame(input logic [7:0] d, input bit w8, input bit pe,
                             input bit po, input bit ts, input int div,
                             input string tag);
    int len = CPT * (div + 1);
    int nb  = w8 ? 8 : 7;
    int guard = 0;
    logic [7:0] got = '0;
    logic [7:0] exp_d;
    logic       exp_p, got_p;
    int         stop_ok = 1;
    while (tx && guard < 500) begin adv(1); guard++; end
    adv(len / 2);
    chk(tx == 1'b0, "R2", {tag, " start bit"}, int'(tx), 0);
    for (int i = 0; i < nb; i++) begin
      adv(len);
      got[i] = tx;
    end
    exp_d = w8 ? d : {1'b0, d[6:0]};
    chk(got == exp_d, w8 ? "R3" : "R3", {tag, " data bits"}, int'(got), int'(exp_d));
    if (pe) begin
      adv(len);
      got_p = tx;
      exp_p = (^exp_d) ^ po;
      chk(got_p == exp_p, "R4", {tag, " parity bit"}, int'(got_p), int'(exp_p));
    end
    for (int s = 0; s < (ts ? 2 : 1); s++) begin
      adv(len);
      if (!(tx && active)) stop_ok = 0;
    end
    chk(stop_ok == 1, "R5", {tag, " stop bits high and active"}, stop_ok, 1);
    adv(len);
    chk(!active && tx, "R6", {tag, " character ends on time"}, int'({active, tx}), 1);
  endtask

  task automatic t_reset;
    chk(tx == 1'b1, "R1", "line after reset", int'(tx), 1);
    chk(!busy && !active, "R1", "flags after reset", int'({busy, active}), 0);
    chk(in_ready == 1'b1, "R10", "ready when enabled idle", int'(in_ready), 1);
    send_byte(8'hA5);
    check_frame(8'hA5, 1, 0, 0, 0, 7, "default divisor 8N1");
  endtask

  task automatic t_div_idle;
    set_div(0);
    chk(busy == 1'b1 && in_ready == 1'b0, "R7", "busy after write", int'({busy, in_ready}), 2);
    adv(1);
    chk(busy == 1'b0, "R7", "busy clears when idle", int'(busy), 0);
    send_byte(8'hA5);
    check_frame(8'hA5, 1, 0, 0, 0, 0, "divisor 0");
  endtask

  task automatic t_seven_bit;
    wide8 = 1'b0;
    send_byte(8'hC3);
    check_frame(8'hC3, 0, 0, 0, 0, 0, "7N1 drops bit7");
    wide8 = 1'b1;
  endtask

  task automatic t_parity;
    par_en = 1'b1;
    par_odd = 1'b0;
    send_byte(8'h13);
    check_frame(8'h13, 1, 1, 0, 0, 0, "8E1 odd ones");
    par_odd = 1'b1;
    send_byte(8'h5A);
    check_frame(8'h5A, 1, 1, 1, 0, 0, "8O1 even ones");
    wide8 = 1'b0;
    send_byte(8'h93);
    check_frame(8'h93, 0, 1, 1, 0, 0, "7O1");
    wide8 = 1'b1;
    par_en = 1'b0;
    par_odd = 1'b0;
  endtask

  task automatic t_two_stop;
    two_stop = 1'b1;
    send_byte(8'h0F);
    check_frame(8'h0F, 1, 0, 0, 1, 0, "8N2");
    two_stop = 1'b0;
  endtask

  task automatic t_div_midframe;
    send_byte(8'hA5);
    fork
      check_frame(8'hA5, 1, 0, 0, 0, 0, "old divisor kept mid-frame");
      begin
        adv(3);
        set_div(3);
        adv(2);
        chk(busy == 1'b1, "R7", "busy held during character", int'(busy), 1);
      end
    join
    chk(busy == 1'b0, "R7", "busy clears after character", int'(busy), 0);
    send_byte(8'hA5);
    check_frame(8'hA5, 1, 0, 0, 0, 3, "new divisor next frame");
  endtask

  task automatic t_break;
    int low_ok = 1;
    send_byte(8'hFF);
    adv(40);
    brk = 1'b1;
    adv(2);
    chk(!tx && !active && !in_ready, "R8", "break drops frame and holds low",
        int'({tx, active, in_ready}), 0);
    for (int i = 0; i < 30; i++) begin adv(1); if (tx) low_ok = 0; end
    chk(low_ok == 1, "R8", "line held low in break", low_ok, 1);
    brk = 1'b0;
    adv(2);
    chk(tx == 1'b1 && in_ready == 1'b1, "R8", "line high after release",
        int'({tx, in_ready}), 3);
    send_byte(8'h3C);
    check_frame(8'h3C, 1, 0, 0, 0, 3, "after break");
  endtask

  task automatic t_disable;
    int quiet = 1;
    tx_en = 1'b0;
    adv(1);
    chk(in_ready == 1'b0, "R9", "ready low when disabled", int'(in_ready), 0);
    in_data = 8'h00;
    in_valid = 1'b1;
    for (int i = 0; i < 40; i++) begin adv(1); if (!tx || active) quiet = 0; end
    in_valid = 1'b0;
    chk(quiet == 1, "R9", "no byte taken while disabled", quiet, 1);
    adv(1);
    chk(active == 1'b0, "R10", "no handshake without ready", int'(active), 0);
    tx_en = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_data = '0; div_val = '0; div_wr = 1'b0;
    tx_en = 1'b1; wide8 = 1'b1; par_en = 1'b0; par_odd = 1'b0; two_stop = 1'b0;
    brk = 1'b0;
    adv(3);
    rst_n = 1'b1;
    adv(4);
    t_reset();
    t_div_idle();
    t_seven_bit();
    t_parity();
    t_two_stop();
    t_div_midframe();
    t_break();
    t_disable();
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule